// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block turns the digitized outputs of the supply monitors into a single global reset for the rest of the chip. The inputs are a power-on detector level, a brown-out detector level and, on package options that bring it out, an external active-low reset pin. All of these are active-low "supply good" style levels. Each one passes through a synchronizer. A falling transition of the combined supervisor level (A) or of the external pin level (B) starts a reset pulse of fixed length, timed by a down-counter clocked by the system clock.

The supervisor level A is the power-on level alone. When the brown-out enable bit is set, it is the power-on level ANDed with the brown-out level. While A stays low after a trigger, the reset output is held and the count is reloaded. The full pulse length runs only once A has recovered. The brown-out enable bit acts like a one-time configuration fuse. It can change only in programming mode. Clearing it also requires the global write-protect flag to be low. The global reset pulse does not clear it.

Top module: `sup_reset_ctrl`

## Requirements
- R1: After the block's own reset input is released, `glob_rst_o` is low and `bor_en_o` equals the parameter `BOR_EN_INIT` (default 0).
- R2: A falling transition of A makes `glob_rst_o` go high after the third rising clock edge following the input change. That edge count covers the two synchronizer stages and one timer register.
- R3: With A and B high again, the pulse lasts exactly `CLK_MHZ * PULSE_US` clock cycles (default 50 cycles, which is 1 us at 50 MHz).
- R4: A equals `por_ok_i` when `bor_en_o` is 0, so a low on `bor_ok_i` has no effect. A equals `por_ok_i & bor_ok_i` when `bor_en_o` is 1.
- R5: While a pulse is active and A is low, `glob_rst_o` stays high. The full pulse length is counted again after A returns high.
- R6: A new falling transition of A or B during an active pulse restarts the count from the full length.
- R7: With `HAS_EXT_PIN=1`, a falling transition of `ext_rst_n_i` triggers a pulse. With `HAS_EXT_PIN=0`, the pin has no effect.
- R8: Only falling transitions trigger. A rising transition starts nothing. A steady low on B does not extend the pulse.
- R9: A write (`cfg_we_i=1`) with data 1 sets `bor_en_o` only when `prog_mode_i=1`. Writes outside programming mode leave the bit unchanged.
- R10: A write with data 0 clears `bor_en_o` only when `prog_mode_i=1` and `wr_prot_i=0`.
- R11: `bor_en_o` keeps its value through global reset pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low initialization of the block itself |
| por_ok_i | input | 1 | Power-on detector level, high when the supply is good |
| bor_ok_i | input | 1 | Brown-out detector level, high when above threshold |
| ext_rst_n_i | input | 1 | External reset pin level, active low |
| prog_mode_i | input | 1 | Programming mode flag |
| wr_prot_i | input | 1 | Global write-protect flag |
| cfg_we_i | input | 1 | Configuration write strobe for the brown-out enable |
| cfg_bor_en_i | input | 1 | Value written to the brown-out enable |
| glob_rst_o | output | 1 | Global reset pulse, active high |
| bor_en_o | output | 1 | Current brown-out enable bit |

## Verification
The bench builds two instances that share the same stimulus. The first uses the defaults (50 cycles, external pin present), so the held and restarted pulses can be measured against a full 1 us window. The second is built with `CLK_MHZ=4` and `HAS_EXT_PIN=0`. Its short 4-cycle pulse brings the exact-length check within a few cycles, and it shows that the pin is ignored when it is configured absent. Both instances are compared on every clock against a behavioural model.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

  typedef enum logic [1:0] {
    CFG_KEEP  = 2'd0,
    CFG_SET   = 2'd1,
    CFG_CLEAR = 2'd2
  } cfg_op_e;

  // Reset pulse length in clock cycles: clock MHz times microseconds, at least 1.
  function automatic int unsigned pulse_cycles(int unsigned mhz, int unsigned us);
    int unsigned n;
    n = mhz * us;
    return (n == 0) ? 1 : n;
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Write rule of the enable bit: set needs programming mode,
  // clear needs programming mode without write protection.
  function automatic cfg_op_e cfg_decode(logic we, logic prog, logic wp, logic d);
    if (!we || !prog) return CFG_KEEP;
    if (d)            return CFG_SET;
    if (!wp)          return CFG_CLEAR;
    return CFG_KEEP;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage_q <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sup_fall_det.sv
module sup_fall_det #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) prev_q <= '1;
    else          prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/sup_bor_cfg.sv
module sup_bor_cfg
  import sup_rst_pkg::*;
#(
  parameter logic INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic prog_i,
  input  logic wp_i,
  input  logic we_i,
  input  logic d_i,
  output logic en_o
);
  cfg_op_e op;
  logic    en_q;

  assign op = cfg_decode(we_i, prog_i, wp_i, d_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      en_q <= INIT;
    end else begin
      case (op)
        CFG_SET:   en_q <= 1'b1;
        CFG_CLEAR: en_q <= 1'b0;
        default:   en_q <= en_q;
      endcase
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/sup_pulse_timer.sv
module sup_pulse_timer #(
  parameter int unsigned CYCLES = 50,
  parameter int unsigned CW     = 6
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic load_i,
  input  logic hold_i,
  output logic active_o
);
  localparam logic [CW-1:0] LOADV = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (load_i || (hold_i && active_o)) begin
      cnt_q <= LOADV;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_rst_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned PULSE_US    = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_EXT_PIN = 1'b1,
  parameter logic        BOR_EN_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic por_ok_i,
  input  logic bor_ok_i,
  input  logic ext_rst_n_i,
  input  logic prog_mode_i,
  input  logic wr_prot_i,
  input  logic cfg_we_i,
  input  logic cfg_bor_en_i,
  output logic glob_rst_o,
  output logic bor_en_o
);
  localparam int unsigned RESET_CYCLES = pulse_cycles(CLK_MHZ, PULSE_US);
  localparam int unsigned CNT_W        = cnt_width(RESET_CYCLES);

  logic [2:0] raw_lvl;
  logic [2:0] sync_lvl;
  logic       a_ok;
  logic       b_ok;
  logic [1:0] falls;
  logic       trig_a;
  logic       trig_b;
  logic       bor_en;
  logic       pulse_active;

  assign raw_lvl = {ext_rst_n_i, bor_ok_i, por_ok_i};

  sup_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (raw_lvl),
    .q_o     (sync_lvl)
  );

  sup_bor_cfg #(.INIT(BOR_EN_INIT)) u_cfg (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .prog_i  (prog_mode_i),
    .wp_i    (wr_prot_i),
    .we_i    (cfg_we_i),
    .d_i     (cfg_bor_en_i),
    .en_o    (bor_en)
  );

  // Combined supervisor level: brown-out joins only when enabled.
  assign a_ok = sync_lvl[0] & (bor_en ? sync_lvl[1] : 1'b1);

  generate
    if (HAS_EXT_PIN) begin : g_ext
      assign b_ok = sync_lvl[2];
    end else begin : g_no_ext
      assign b_ok = 1'b1;
    end
  endgenerate

  sup_fall_det #(.WIDTH(2)) u_fall (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .lvl_i   ({b_ok, a_ok}),
    .fall_o  (falls)
  );

  assign trig_a = falls[0];
  assign trig_b = falls[1];

  sup_pulse_timer #(.CYCLES(RESET_CYCLES), .CW(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .load_i   (trig_a | trig_b),
    .hold_i   (~a_ok),
    .active_o (pulse_active)
  );

  assign glob_rst_o = pulse_active;
  assign bor_en_o   = bor_en;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk (
  input logic clk_i,
  input logic rst_n_i,
  input logic prog_mode_i,
  input logic wr_prot_i,
  input logic cfg_we_i,
  input logic cfg_bor_en_i,
  input logic glob_rst_o,
  input logic bor_en_o,
  input logic trig_a,
  input logic trig_b,
  input logic a_ok
);
  AST_TRIG_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (trig_a || trig_b) |=> glob_rst_o); // R2

  AST_RISE_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(glob_rst_o) |-> $past(trig_a || trig_b)); // R8

  AST_RELEASE_NEEDS_A_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(glob_rst_o) |-> $past(a_ok)); // R5

  AST_EN_FROZEN_OUTSIDE_PROG: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !prog_mode_i |=> $stable(bor_en_o)); // R9

  AST_SET_IN_PROG: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (prog_mode_i && cfg_we_i && cfg_bor_en_i) |=> bor_en_o); // R9

  AST_NO_CLEAR_PROTECTED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_prot_i && bor_en_o) |=> bor_en_o); // R10

  AST_EN_SURVIVES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (glob_rst_o && bor_en_o && !cfg_we_i) |=> bor_en_o); // R11
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .prog_mode_i  (prog_mode_i),
  .wr_prot_i    (wr_prot_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_bor_en_i (cfg_bor_en_i),
  .glob_rst_o   (glob_rst_o),
  .bor_en_o     (bor_en_o),
  .trig_a       (trig_a),
  .trig_b       (trig_b),
  .a_ok         (a_ok)
);

// File: tb/sup_reset_ctrl_tb_top.sv
module sup_ref_model #(
  parameter int RC      = 50,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por,
  input  logic bor,
  input  logic ext,
  input  logic prog,
  input  logic wp,
  input  logic we,
  input  logic d,
  output logic rst_m,
  output logic en_m
);
  // Behavioural model: input history in queues, pulse timing in an integer.
  logic hist_por[$];
  logic hist_bor[$];
  logic hist_ext[$];
  int   left;
  bit   last_a, last_b, en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_por = '{1'b1, 1'b1};
      hist_bor = '{1'b1, 1'b1};
      hist_ext = '{1'b1, 1'b1};
      left = 0; last_a = 1; last_b = 1; en = 0;
    end else begin
      bit a_now, b_now;
      a_now = hist_por[0] && (!en || hist_bor[0]);
      b_now = HAS_EXT ? hist_ext[0] : 1'b1;
      if ((last_a && !a_now) || (last_b && !b_now)) left = RC;
      else if (left > 0 && !a_now) left = RC;
      else if (left > 0) left = left - 1;
      last_a = a_now;
      last_b = b_now;
      void'(hist_por.pop_front()); hist_por.push_back(por);
      void'(hist_bor.pop_front()); hist_bor.push_back(bor);
      void'(hist_ext.pop_front()); hist_ext.push_back(ext);
      if (we && prog) begin
        if (d) en = 1;
        else if (!wp) en = 0;
      end
    end
    rst_m = (left > 0);
    en_m  = en;
  end
endmodule

module sup_reset_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1, bor = 1, ext = 1, prog = 0, wp = 0, we = 0, d = 0;
  logic g1, e1, g2, e2, mg1, me1, mg2, me2;
  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  sup_reset_ctrl dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .por_ok_i(por), .bor_ok_i(bor),
    .ext_rst_n_i(ext), .prog_mode_i(prog), .wr_prot_i(wp), .cfg_we_i(we),
    .cfg_bor_en_i(d), .glob_rst_o(g1), .bor_en_o(e1));

  sup_reset_ctrl #(.CLK_MHZ(4), .HAS_EXT_PIN(1'b0)) dut_short_i (
    .clk_i(clk), .rst_n_i(rst_n), .por_ok_i(por), .bor_ok_i(bor),
    .ext_rst_n_i(ext), .prog_mode_i(prog), .wr_prot_i(wp), .cfg_we_i(we),
    .cfg_bor_en_i(d), .glob_rst_o(g2), .bor_en_o(e2));

  sup_ref_model #(.RC(50), .HAS_EXT(1'b1)) ref1 (
    .clk(clk), .rst_n(rst_n), .por(por), .bor(bor), .ext(ext), .prog(prog),
    .wp(wp), .we(we), .d(d), .rst_m(mg1), .en_m(me1));

  sup_ref_model #(.RC(4), .HAS_EXT(1'b0)) ref2 (
    .clk(clk), .rst_n(rst_n), .por(por), .bor(bor), .ext(ext), .prog(prog),
    .wp(wp), .we(we), .d(d), .rst_m(mg2), .en_m(me2));

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Count how many of the next n samples have reset high (per instance).
  task automatic width(int n, output int w1, output int w2);
    w1 = 0; w2 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (g1) w1++;
      if (g2) w2++;
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, g1, mg1, "model rst dut_i");
      chk(cur_req, e1, me1, "model en dut_i");
      chk(cur_req, g2, mg2, "model rst short");
      chk(cur_req, e2, me2, "model en short");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w1, w2;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1", g1, 0, "glob after init");
    chk("R1", e1, 0, "bor_en after init");
    cmp_on = 1;

    // R2 / R3: one-cycle dip on power-on level
    cur_req = "R3";
    por = 0; cyc(1); por = 1;
    chk("R2", g1, 0, "not yet high after 1 edge");
    cyc(1);
    chk("R2", g1, 0, "not yet high after 2 edges");
    cyc(1);
    chk("R2", g1, 1, "high after 3rd edge");
    width(70, w1, w2);
    chk("R3", w1 + 1, 50, "pulse width default");
    chk("R3", w2 + 1, 4, "pulse width short");

    // R4: brown-out ignored while disabled
    cur_req = "R4";
    bor = 0;
    width(12, w1, w2);
    chk("R4", w1, 0, "bor low with enable off");
    bor = 1; cyc(4);

    // R9: set refused outside programming mode, accepted inside
    cur_req = "R9";
    we = 1; d = 1; cyc(1); we = 0;
    chk("R9", e1, 0, "set outside prog");
    prog = 1; we = 1; cyc(1); we = 0; prog = 0;
    chk("R9", e1, 1, "set in prog");
    cyc(2);

    // R4 / R5: brown-out now triggers and holds
    cur_req = "R5";
    bor = 0; cyc(80);
    chk("R4", g1, 1, "bor low with enable on");
    chk("R5", g1, 1, "held while bor low");
    bor = 1; cyc(40);
    chk("R5", g1, 1, "full length after recovery");
    cyc(30);
    chk("R5", g1, 0, "released after recovery");
    chk("R11", e1, 1, "enable kept through pulse");

    // R6: second edge restarts the count
    cur_req = "R6";
    por = 0; cyc(1); por = 1; cyc(19);
    por = 0; cyc(1); por = 1;
    cyc(44);
    chk("R6", g1, 1, "restarted pulse still high");
    cyc(15);
    chk("R6", g1, 0, "restarted pulse ended");

    // R7: external pin present vs absent
    cur_req = "R7";
    ext = 0; cyc(1); ext = 1;
    width(12, w1, w2);
    chk("R7", w1 > 0, 1, "ext pin triggers");
    chk("R7", w2, 0, "ext pin ignored when absent");
    cyc(50);

    // R8: steady low does not extend, rising edge starts nothing
    cur_req = "R8";
    ext = 0; cyc(70);
    chk("R8", g1, 0, "steady ext low does not hold");
    ext = 1;
    width(12, w1, w2);
    chk("R8", w1, 0, "rising edge ignored");

    // R10: clear blocked by protection and outside prog mode
    cur_req = "R10";
    we = 1; d = 0; cyc(1); we = 0;
    chk("R10", e1, 1, "clear outside prog");
    prog = 1; wp = 1; we = 1; cyc(1); we = 0;
    chk("R10", e1, 1, "clear with protection");
    wp = 0; we = 1; cyc(1); we = 0; prog = 0;
    chk("R10", e1, 0, "clear in prog unprotected");
    cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule